// File: doc/BRIEF.md
# Cascaded Lookup Trigger Reducer

This block turns a wide pattern of trigger-cell hits into a short trigger word. The input pattern is cut into three equal slices. Each slice addresses a first-level lookup memory of its own, and each of these memories yields a narrow code. The three codes are joined into one address for a final lookup memory, whose entry is the trigger word. The memories are loaded by software, so any topological selection rule can be expressed as table contents. A table full of zeros produces no trigger, and clearing the tables is how a cell is masked.

A small host register port reaches every table through its own address window. The same port holds a debug pattern register that can take over the output, and a control register that returns the output to lookup results or starts a hardware sweep that zeroes all four tables. The sweep also runs by itself after reset.

The default parameters make small tables so that the block elaborates quickly. The full-size configuration uses SLICE_W=12 and MID_W=5, which gives first-level tables of 4096 entries and a final table of 32768 entries.

Top module: `lutc_tree`

## Requirements
- R1: Reset starts a clear sweep. `clr_busy` is high from reset for exactly 2^SW_W cycles, where SW_W = max(SLICE_W, 3*MID_W). After the sweep every table entry reads zero and the control register reads 0.
- R2: Table 1 is addressed by trig_in[IN_W-1:2*SLICE_W], table 2 by the middle slice and table 3 by trig_in[SLICE_W-1:0]. The final table address is {table1, table2, table3}, with table 1 in the most significant bits.
- R3: In lookup mode, trig_out shows the result for a trig_in value that was sampled at clock edge t from just after edge t+2. This comes from three register stages: input, first level and final level. A new input can be accepted every cycle.
- R4: host_addr[18:16] selects the window: 0 to 2 select tables 1 to 3, 3 selects the final table, 4 selects the pattern register and 5 selects the control register. host_addr[15:0] is the entry offset. A write keeps only the low bits that fit the entry width. A read returns the value zero-extended to 16 bits, one cycle later, with host_rvalid high.
- R5: A write to window 4 stores host_wdata[OUT_W-1:0] as the pattern and enters pattern mode. From the next cycle trig_out equals the pattern, whatever trig_in does. Reading window 4 returns the pattern.
- R6: A write to window 5 leaves pattern mode. If host_wdata[0] is 1 and no sweep is running, the write also starts a clear sweep. Reading window 5 returns bit 0 = pattern mode and bit 1 = sweep busy.
- R7: After a commanded sweep, trig_out in lookup mode is 0 for every input.
- R8: While a sweep runs, host writes to the tables and further clear commands have no effect: the entry stays zero and the sweep length does not change.
- R9: An access to an offset beyond a table's depth, or to windows 6 and 7, writes nothing and reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_in | input | IN_W (3*SLICE_W) | Trigger-cell hit pattern |
| trig_out | output | OUT_W | Trigger word, or the debug pattern in pattern mode |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | 19 | Host address: window in [18:16], offset in [15:0] |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data, valid with host_rvalid |
| host_rvalid | output | 1 | Read data valid, one cycle after host_rd |
| clr_busy | output | 1 | Clear sweep in progress |

## Verification
The hardest condition to reach is a host access that arrives during a sweep, because it must lose to the sweep without leaving a trace. The bench starts a sweep from the control register. While the sweep runs, it writes a nonzero value to a first-level entry and issues a second clear command. Afterwards it reads the entry back as zero and measures that the busy window still lasted exactly 2^SW_W cycles. The input order and concatenation order are exposed by loading each table with a different function, so that a swapped slice changes the trigger word. A scoreboard then checks a new input every cycle at the three-cycle latency.

// File: rtl/lutc_pkg.sv
package lutc_pkg;
    localparam int HOST_AW = 19;
    localparam int HOST_DW = 16;
    localparam int OFS_W   = 16;
    localparam int NUM_TBL = 4;

    typedef enum logic [2:0] {
        WIN_TBL1    = 3'd0,
        WIN_TBL2    = 3'd1,
        WIN_TBL3    = 3'd2,
        WIN_FINAL   = 3'd3,
        WIN_PATTERN = 3'd4,
        WIN_CONTROL = 3'd5
    } win_e;
endpackage

// File: rtl/lutc_mem.sv
module lutc_mem #(
    parameter int AW = 8,
    parameter int DW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] lk_addr,
    output logic [DW-1:0] lk_q,
    input  logic [AW-1:0] hs_addr,
    output logic [DW-1:0] hs_data
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] lk_d;

    // table storage, written by host or by the clear sweep
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    always_comb lk_d = mem[lk_addr];

    always_ff @(posedge clk) begin
        if (rst) lk_q <= '0;
        else     lk_q <= lk_d;
    end

    assign hs_data = mem[hs_addr];
endmodule

// File: rtl/lutc_host_dec.sv
module lutc_host_dec
    import lutc_pkg::*;
#(
    parameter int SLICE_W = 8,
    parameter int FA_W    = 9,
    parameter int SW_W    = 9
) (
    input  logic                host_wr,
    input  logic [HOST_AW-1:0]  host_addr,
    input  logic [HOST_DW-1:0]  host_wdata,
    input  logic                busy,
    input  logic [SW_W-1:0]     sweep_cnt,
    output logic [2:0]          win,
    output logic [OFS_W-1:0]    ofs,
    output logic [NUM_TBL-1:0]  tbl_hit,
    output logic [NUM_TBL-1:0]  tbl_we,
    output logic [OFS_W-1:0]    tbl_waddr,
    output logic [HOST_DW-1:0]  tbl_wdata,
    output logic                pat_we,
    output logic                ctrl_we
);
    logic [OFS_W-1:0]   sweep_ext;
    logic [NUM_TBL-1:0] ofs_ok;
    logic [NUM_TBL-1:0] sw_ok;

    assign win = host_addr[HOST_AW-1:OFS_W];
    assign ofs = host_addr[OFS_W-1:0];

    always_comb begin
        sweep_ext = '0;
        sweep_ext[SW_W-1:0] = sweep_cnt;
    end

    // per-table range check, write enable and hit
    for (genvar i = 0; i < NUM_TBL; i++) begin : g_tbl
        localparam int TAW = (i < NUM_TBL - 1) ? SLICE_W : FA_W;
        assign ofs_ok[i]  = (ofs >> TAW) == '0;
        assign sw_ok[i]   = (sweep_ext >> TAW) == '0;
        assign tbl_hit[i] = (win == 3'(i)) && ofs_ok[i];
        assign tbl_we[i]  = busy ? sw_ok[i] : (host_wr && tbl_hit[i]);
    end

    assign tbl_waddr = busy ? sweep_ext : ofs;
    assign tbl_wdata = busy ? '0 : host_wdata;
    assign pat_we    = host_wr && (win == WIN_PATTERN);
    assign ctrl_we   = host_wr && (win == WIN_CONTROL);
endmodule

// File: rtl/lutc_tree.sv
module lutc_tree
    import lutc_pkg::*;
#(
    parameter int SLICE_W = 8,
    parameter int MID_W   = 3,
    parameter int OUT_W   = 8,
    localparam int IN_W   = 3 * SLICE_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [IN_W-1:0]     trig_in,
    output logic [OUT_W-1:0]    trig_out,
    input  logic                host_wr,
    input  logic                host_rd,
    input  logic [HOST_AW-1:0]  host_addr,
    input  logic [HOST_DW-1:0]  host_wdata,
    output logic [HOST_DW-1:0]  host_rdata,
    output logic                host_rvalid,
    output logic                clr_busy
);
    localparam int FA_W = 3 * MID_W;
    localparam int SW_W = (SLICE_W > FA_W) ? SLICE_W : FA_W;
    localparam logic [SW_W-1:0] SWEEP_LAST = '1;

    typedef struct packed {
        logic [IN_W-1:0]    in;
        logic               pat_mode;
        logic [OUT_W-1:0]   pattern;
        logic               busy;
        logic [SW_W-1:0]    cnt;
        logic [HOST_DW-1:0] rdata;
        logic               rvalid;
    } state_t;

    state_t st_d, st_q;

    logic [2:0]          win;
    logic [OFS_W-1:0]    ofs;
    logic [NUM_TBL-1:0]  tbl_hit, tbl_we;
    logic [OFS_W-1:0]    tbl_waddr;
    logic [HOST_DW-1:0]  tbl_wdata;
    logic                pat_we, ctrl_we;
    logic                pat_mode_q;

    logic [MID_W-1:0]    lvl1_q  [3];
    logic [MID_W-1:0]    lvl1_hs [3];
    logic [FA_W-1:0]     final_addr;
    logic [OUT_W-1:0]    final_q;
    logic [OUT_W-1:0]    final_hs;
    logic [HOST_DW-1:0]  rd_mux;

    lutc_host_dec #(
        .SLICE_W (SLICE_W),
        .FA_W    (FA_W),
        .SW_W    (SW_W)
    ) u_dec (
        .host_wr    (host_wr),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .busy       (st_q.busy),
        .sweep_cnt  (st_q.cnt),
        .win        (win),
        .ofs        (ofs),
        .tbl_hit    (tbl_hit),
        .tbl_we     (tbl_we),
        .tbl_waddr  (tbl_waddr),
        .tbl_wdata  (tbl_wdata),
        .pat_we     (pat_we),
        .ctrl_we    (ctrl_we)
    );

    // first level: g=0 is table 1 on the top slice
    for (genvar g = 0; g < 3; g++) begin : g_lvl1
        logic [SLICE_W-1:0] slice;
        assign slice = st_q.in[IN_W-1-g*SLICE_W -: SLICE_W];
        lutc_mem #(.AW(SLICE_W), .DW(MID_W)) u_mem (
            .clk     (clk),
            .rst     (rst),
            .we      (tbl_we[g]),
            .waddr   (tbl_waddr[SLICE_W-1:0]),
            .wdata   (tbl_wdata[MID_W-1:0]),
            .lk_addr (slice),
            .lk_q    (lvl1_q[g]),
            .hs_addr (ofs[SLICE_W-1:0]),
            .hs_data (lvl1_hs[g])
        );
    end

    assign final_addr = {lvl1_q[0], lvl1_q[1], lvl1_q[2]};

    lutc_mem #(.AW(FA_W), .DW(OUT_W)) u_final (
        .clk     (clk),
        .rst     (rst),
        .we      (tbl_we[NUM_TBL-1]),
        .waddr   (tbl_waddr[FA_W-1:0]),
        .wdata   (tbl_wdata[OUT_W-1:0]),
        .lk_addr (final_addr),
        .lk_q    (final_q),
        .hs_addr (ofs[FA_W-1:0]),
        .hs_data (final_hs)
    );

    // host read mux
    always_comb begin
        rd_mux = '0;
        case (win_e'(win))
            WIN_TBL1:    if (tbl_hit[0]) rd_mux[MID_W-1:0] = lvl1_hs[0];
            WIN_TBL2:    if (tbl_hit[1]) rd_mux[MID_W-1:0] = lvl1_hs[1];
            WIN_TBL3:    if (tbl_hit[2]) rd_mux[MID_W-1:0] = lvl1_hs[2];
            WIN_FINAL:   if (tbl_hit[3]) rd_mux[OUT_W-1:0] = final_hs;
            WIN_PATTERN: rd_mux[OUT_W-1:0] = st_q.pattern;
            WIN_CONTROL: rd_mux[1:0] = {st_q.busy, st_q.pat_mode};
            default:     rd_mux = '0;
        endcase
    end

    // next-state
    always_comb begin
        st_d        = st_q;
        st_d.in     = trig_in;
        st_d.rvalid = host_rd;
        if (host_rd) st_d.rdata = rd_mux;

        if (st_q.busy) begin
            if (st_q.cnt == SWEEP_LAST) begin
                st_d.busy = 1'b0;
                st_d.cnt  = '0;
            end else begin
                st_d.cnt  = st_q.cnt + SW_W'(1);
            end
        end

        if (pat_we) begin
            st_d.pattern  = host_wdata[OUT_W-1:0];
            st_d.pat_mode = 1'b1;
        end

        if (ctrl_we) begin
            st_d.pat_mode = 1'b0;
            if (host_wdata[0] && !st_q.busy) begin
                st_d.busy = 1'b1;
                st_d.cnt  = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= '0;
            st_q.busy <= 1'b1;
        end else begin
            st_q      <= st_d;
        end
    end

    assign pat_mode_q  = st_q.pat_mode;
    assign trig_out    = st_q.pat_mode ? st_q.pattern : final_q;
    assign host_rdata  = st_q.rdata;
    assign host_rvalid = st_q.rvalid;
    assign clr_busy    = st_q.busy;
endmodule

// File: rtl/lutc_tree_chk.sv
module lutc_tree_chk #(
    parameter int SLICE_W = 8,
    parameter int MID_W   = 3,
    parameter int OUT_W   = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             host_wr,
    input logic             host_rd,
    input logic [18:0]      host_addr,
    input logic [15:0]      host_wdata,
    input logic             host_rvalid,
    input logic [OUT_W-1:0] trig_out,
    input logic             clr_busy,
    input logic             pat_mode
);
    localparam int FA_W = 3 * MID_W;
    localparam int SW_W = (SLICE_W > FA_W) ? SLICE_W : FA_W;
    localparam logic [SW_W:0] RUN_FULL = {1'b1, {SW_W{1'b0}}};

    logic [SW_W:0] run_q;

    always_ff @(posedge clk) begin
        if (rst)           run_q <= '0;
        else if (clr_busy) run_q <= run_q + 1'b1;
        else               run_q <= '0;
    end

    AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (rst)
        $fell(clr_busy) |-> run_q == RUN_FULL); // R1
    AST_READ_LATENCY: assert property (@(posedge clk) disable iff (rst)
        host_rd |=> host_rvalid); // R4
    AST_NO_SPURIOUS_RVALID: assert property (@(posedge clk) disable iff (rst)
        !host_rd |=> !host_rvalid); // R4
    AST_PATTERN_SHOWN: assert property (@(posedge clk) disable iff (rst)
        (host_wr && host_addr[18:16] == 3'd4) |=> trig_out == $past(host_wdata[OUT_W-1:0])); // R5
    AST_PATTERN_ENTER: assert property (@(posedge clk) disable iff (rst)
        (host_wr && host_addr[18:16] == 3'd4) |=> pat_mode); // R5
    AST_CONTROL_EXIT: assert property (@(posedge clk) disable iff (rst)
        (host_wr && host_addr[18:16] == 3'd5) |=> !pat_mode); // R6
    AST_SWEEP_START: assert property (@(posedge clk) disable iff (rst)
        (host_wr && host_addr[18:16] == 3'd5 && host_wdata[0] && !clr_busy) |=> clr_busy); // R6
endmodule

bind lutc_tree lutc_tree_chk #(
    .SLICE_W (SLICE_W),
    .MID_W   (MID_W),
    .OUT_W   (OUT_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .host_wr     (host_wr),
    .host_rd     (host_rd),
    .host_addr   (host_addr),
    .host_wdata  (host_wdata),
    .host_rvalid (host_rvalid),
    .trig_out    (trig_out),
    .clr_busy    (clr_busy),
    .pat_mode    (pat_mode_q)
);

// File: tb/lutc_tree_bench.sv
`timescale 1ns/1ps
module lutc_tree_bench;
    localparam int SLICE_W = 8;
    localparam int MID_W   = 3;
    localparam int OUT_W   = 8;
    localparam int IN_W    = 3 * SLICE_W;
    localparam int D1      = 1 << SLICE_W;
    localparam int D4      = 1 << (3 * MID_W);
    localparam int SWEEP   = (D1 > D4) ? D1 : D4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [IN_W-1:0]   trig_in = '0;
    logic [OUT_W-1:0]  trig_out;
    logic              host_wr = 1'b0;
    logic              host_rd = 1'b0;
    logic [18:0]       host_addr = '0;
    logic [15:0]       host_wdata = '0;
    logic [15:0]       host_rdata;
    logic              host_rvalid;
    logic              clr_busy;

    int n_chk = 0;
    int n_err = 0;
    int cycle = 0;

    int m1 [D1];
    int m2 [D1];
    int m3 [D1];
    int m4 [D4];

    typedef struct { int exp; int due; } item_t;
    item_t sbq [$];

    always #4 clk = ~clk;
    always @(posedge clk) cycle <= cycle + 1;

    lutc_tree #(.SLICE_W(SLICE_W), .MID_W(MID_W), .OUT_W(OUT_W)) u_lutc_tree (
        .clk(clk), .rst(rst), .trig_in(trig_in), .trig_out(trig_out),
        .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .host_rvalid(host_rvalid), .clr_busy(clr_busy)
    );

    function automatic int f1(int a); return (a * 5 + 1) & 7; endfunction
    function automatic int f2(int a); return ((a * 3) ^ (a >> 3)) & 7; endfunction
    function automatic int f3(int a); return (a ^ (a >> 2) ^ (a >> 5) ^ 2) & 7; endfunction
    function automatic int f4(int a); return (a * 37 + 11) & 255; endfunction

    function automatic logic [18:0] ha(int w, int o);
        return {3'(w), 16'(o)};
    endfunction

    function automatic int exp_out(logic [IN_W-1:0] v);
        int idx;
        idx = (m1[v[23:16]] << (2 * MID_W)) | (m2[v[15:8]] << MID_W) | m3[v[7:0]];
        return m4[idx];
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic host_write(input logic [18:0] a, input logic [15:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic host_read(input logic [18:0] a, output int d);
        @(negedge clk);
        host_rd = 1'b1; host_addr = a;
        @(negedge clk);
        host_rd = 1'b0;
        d = int'(host_rdata);
        chk("R4 rvalid", int'(host_rvalid), 1);
    endtask

    // driver: one input per cycle, expected word queued with its due cycle
    task automatic stream(input int n, input int seed);
        logic [IN_W-1:0] v;
        v = IN_W'(seed);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (i == 0)      v = '0;
            else if (i == 1) v = '1;
            else             v = v * 24'd1103515 + 24'd12345;
            trig_in = v;
            sbq.push_back('{exp_out(v), cycle + 3});
        end
        while (sbq.size() > 0) @(negedge clk);
    endtask

    // monitor
    initial begin
        forever begin
            @(negedge clk);
            if (sbq.size() > 0 && sbq[0].due <= cycle) begin
                item_t it;
                it = sbq.pop_front();
                chk("R2/R3 stream", (it.due == cycle) ? int'(trig_out) : -1, it.exp);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_err++; n_chk++;
        $display("FAIL R1 watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        int rd, c0;
        foreach (m1[i]) begin m1[i] = 0; m2[i] = 0; m3[i] = 0; end
        foreach (m4[i]) m4[i] = 0;

        repeat (5) @(negedge clk);
        rst = 1'b0;
        chk("R1 busy after reset", int'(clr_busy), 1);
        chk("R1 rvalid after reset", int'(host_rvalid), 0);
        c0 = cycle;
        while (clr_busy) @(negedge clk);
        chk("R1 sweep length", cycle - c0, SWEEP);
        host_read(ha(0, 17), rd);   chk("R1 table1 zero", rd, 0);
        host_read(ha(3, 300), rd);  chk("R1 final zero", rd, 0);
        host_read(ha(5, 0), rd);    chk("R1 control idle", rd, 0);

        // load tables with upper junk bits that must be dropped
        for (int a = 0; a < D1; a++) begin
            host_write(ha(0, a), 16'hFFF8 | 16'(f1(a))); m1[a] = f1(a);
            host_write(ha(1, a), 16'hFFF8 | 16'(f2(a))); m2[a] = f2(a);
            host_write(ha(2, a), 16'hFFF8 | 16'(f3(a))); m3[a] = f3(a);
        end
        for (int a = 0; a < D4; a++) begin
            host_write(ha(3, a), 16'hFF00 | 16'(f4(a))); m4[a] = f4(a);
        end
        host_read(ha(0, 9), rd);    chk("R4 table1 readback", rd, f1(9));
        host_read(ha(2, 200), rd);  chk("R4 table3 readback", rd, f3(200));
        host_read(ha(3, 400), rd);  chk("R4 final readback", rd, f4(400));

        // out-of-range and unused windows
        host_write(ha(0, D1), 16'h0007);
        host_read(ha(0, 0), rd);    chk("R9 no alias write", rd, f1(0));
        host_read(ha(0, D1), rd);   chk("R9 beyond depth reads 0", rd, 0);
        host_write(ha(3, D4), 16'h0077);
        host_read(ha(3, 0), rd);    chk("R9 final no alias", rd, f4(0));
        host_read(ha(6, 0), rd);    chk("R9 window 6 reads 0", rd, 0);

        stream(200, 7);

        // pattern override
        trig_in = 24'h123456;
        host_write(ha(4, 0), 16'hFF5A);
        chk("R5 pattern shown", int'(trig_out), 8'h5A);
        trig_in = 24'hABCDEF;
        repeat (4) @(negedge clk);
        chk("R5 pattern holds", int'(trig_out), 8'h5A);
        host_read(ha(4, 0), rd);    chk("R5 pattern readback", rd, 16'h005A);
        host_read(ha(5, 0), rd);    chk("R6 control shows mode", rd, 1);
        host_write(ha(5, 0), 16'h0000);
        chk("R6 lookup restored", int'(trig_out), exp_out(trig_in));
        host_read(ha(5, 0), rd);    chk("R6 mode cleared", rd, 0);

        // commanded sweep with interfering accesses
        host_write(ha(5, 0), 16'h0001);
        chk("R6 sweep started", int'(clr_busy), 1);
        c0 = cycle;
        host_write(ha(0, 5), 16'h0003);
        host_write(ha(5, 0), 16'h0001);
        while (clr_busy) @(negedge clk);
        chk("R8 sweep not restarted", cycle - c0, SWEEP);
        foreach (m1[i]) begin m1[i] = 0; m2[i] = 0; m3[i] = 0; end
        foreach (m4[i]) m4[i] = 0;
        host_read(ha(0, 5), rd);    chk("R8 busy write dropped", rd, 0);
        host_read(ha(3, 100), rd);  chk("R7 final cleared", rd, 0);
        trig_in = 24'h5A5A5A;
        repeat (4) @(negedge clk);
        chk("R7 masked output", int'(trig_out), 0);
        stream(20, 3);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule